// File: doc/BRIEF.md
# Segmented Sequential Carry-less Polynomial Multiplier

This block forms the full, unreduced product of two binary polynomials of degree below `M`, whose coefficients lie in GF(2). Coefficient addition is XOR, so no carries propagate. A full-width combinational multiplier would be too large. The block therefore uses one small carry-less core and runs it over several clock cycles. Each operand is zero-extended to a whole number of segments and cut into equal slices. On every cycle, one slice of A and one slice of B go through the core. The resulting partial product is XOR-folded into an accumulator in that same cycle, at a bit offset fixed by wiring.

A `start` pulse in the idle state latches both operands and clears the accumulator. The controller then steps through every slice pair, with the B slice index moving fastest. One cycle after the last pair, it raises `done` for exactly one cycle. The product stays unchanged until the next accepted start. The controller has three states. IDLE accepts `start` (transition IDLE→RUN). RUN accumulates one pair per cycle and stays in RUN until the last pair (transition RUN→FINISH). FINISH drives `done` and always returns to IDLE (transition FINISH→IDLE). A `start` seen in RUN or FINISH is ignored.

The parameter `ASYMMETRIC` selects the slicing. When it is 0, both operands use slices of `CORE_W` bits. When it is 1, A uses `ASYM_WA`-bit slices and B uses `ASYM_WB`-bit slices, and the core becomes rectangular. `ASYM_WA = 1` with `ASYM_WB = M` gives a bit-serial multiplier. Reduction modulo a field polynomial is left to a later stage.

Top module: `seg_clmul`

## Requirements
- R1: `product` equals the carry-less product of `a` and `b`: bit k is the XOR over all i+j=k of a[i]&b[j], for k in 0..2M-2.
- R2: With `ASYMMETRIC=0` and KS = ceil(M/CORE_W), `done` is high in the KS*KS-th cycle after the clock edge that accepted `start`.
- R3: `done` is high for exactly one cycle per operation.
- R4: From the cycle `done` is high until the next accepted start, `product` holds its value, whatever `a` and `b` do.
- R5: A `start` pulse while an operation is in RUN or FINISH is ignored: the running operation keeps its timing and its result from the operands latched at its own start.
- R6: Results are correct when M is not a multiple of the slice width; each operand is zero-extended to KA*WA and KB*WB bits before slicing.
- R7: With `ASYMMETRIC=1`, `done` arrives ceil(M/ASYM_WA)*ceil(M/ASYM_WB) cycles after start. With ASYM_WA=1 and ASYM_WB=M, the block works bit-serially and takes M cycles.
- R8: While `rst_n` is low, `done` is 0 and `product` is all zeros.
- R9: An accepted start clears the accumulator: in the cycle after acceptance, `product` reads zero, so no earlier result leaks into the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the block is in IDLE |
| a | input | M | Operand A; bit i is the coefficient of x^i |
| b | input | M | Operand B; bit i is the coefficient of x^i |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*M-1 | Unreduced carry-less product |

## Verification
The latency and hold assertions assume that `start` is a synchronous level that is sampled only at clock edges. They also assume that no start is expected to take effect while the block is busy. The bench drives `start`, `a` and `b` on falling edges so that every rising edge sees settled values. It raises `start` only in IDLE, except for the deliberate mid-run pulses that exercise R5. Random operands from a fixed seed are mixed with all-ones, zero and single-bit corner operands, for both a square and a bit-serial instance.

// File: rtl/seg_clmul_pkg.sv
package seg_clmul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/seg_clmul_core.sv
// Rectangular combinational carry-less multiplier: WA x WB bits.
module seg_clmul_core #(
    parameter int WA = 6,
    parameter int WB = 6,
    localparam int PW = WA + WB - 1
) (
    input  logic [WA-1:0] op_a,
    input  logic [WB-1:0] op_b,
    output logic [PW-1:0] pp
);
    logic [PW-1:0] row [WA];

    for (genvar r = 0; r < WA; r++) begin : g_row
        assign row[r] = op_a[r] ? (PW'(op_b) << r) : '0;
    end

    always_comb begin
        pp = '0;
        for (int r = 0; r < WA; r++) begin
            pp = pp ^ row[r];
        end
    end
endmodule

// File: rtl/seg_clmul_opreg.sv
// Latches zero-extended operands and presents the addressed slices.
module seg_clmul_opreg #(
    parameter int M  = 16,
    parameter int WA = 6,
    parameter int WB = 6,
    parameter int KA = 3,
    parameter int KB = 3,
    localparam int IA_W = (KA > 1) ? $clog2(KA) : 1,
    localparam int IB_W = (KB > 1) ? $clog2(KB) : 1,
    localparam int EA = KA * WA,
    localparam int EB = KB * WB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [M-1:0]    a_in,
    input  logic [M-1:0]    b_in,
    input  logic [IA_W-1:0] idx_a,
    input  logic [IB_W-1:0] idx_b,
    output logic [WA-1:0]   seg_a,
    output logic [WB-1:0]   seg_b
);
    logic [EA-1:0] a_q;
    logic [EB-1:0] b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= EA'(a_in);
            b_q <= EB'(b_in);
        end
    end

    assign seg_a = a_q[idx_a * WA +: WA];
    assign seg_b = b_q[idx_b * WB +: WB];
endmodule

// File: rtl/seg_clmul_seq.sv
// Pair-scheduling controller: outer index over A slices, inner over B slices.
module seg_clmul_seq
    import seg_clmul_pkg::*;
#(
    parameter int KA = 3,
    parameter int KB = 3,
    localparam int IA_W = (KA > 1) ? $clog2(KA) : 1,
    localparam int IB_W = (KB > 1) ? $clog2(KB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [IA_W-1:0] idx_a,
    output logic [IB_W-1:0] idx_b,
    output logic            load,
    output logic            acc_en,
    output logic            busy,
    output logic            done
);
    localparam logic [IA_W-1:0] LAST_A = IA_W'(KA - 1);
    localparam logic [IB_W-1:0] LAST_B = IB_W'(KB - 1);

    seq_state_e state, nxt;
    logic       last_pair;

    assign last_pair = (idx_a == LAST_A) && (idx_b == LAST_B);

    // State and index registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_a <= '0;
            idx_b <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                idx_a <= '0;
                idx_b <= '0;
            end else if (state == ST_RUN) begin
                if (idx_b == LAST_B) begin
                    idx_b <= '0;
                    idx_a <= (idx_a == LAST_A) ? '0 : idx_a + 1'b1;
                end else begin
                    idx_b <= idx_b + 1'b1;
                end
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = start ? ST_RUN : ST_IDLE;
            ST_RUN:    nxt = last_pair ? ST_FINISH : ST_RUN;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load   = 1'b0;
        acc_en = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load = start;
                busy = 1'b0;
            end
            ST_RUN:    acc_en = 1'b1;
            ST_FINISH: done   = 1'b1;
            default:   busy   = 1'b0;
        endcase
    end
endmodule

// File: rtl/seg_clmul_acc.sv
// XOR accumulator; each slice pair has a fixed, wired placement offset.
module seg_clmul_acc #(
    parameter int WA = 6,
    parameter int WB = 6,
    parameter int KA = 3,
    parameter int KB = 3,
    localparam int PW   = WA + WB - 1,
    localparam int AW   = KA * WA + KB * WB - 1,
    localparam int NP   = KA * KB,
    localparam int IA_W = (KA > 1) ? $clog2(KA) : 1,
    localparam int IB_W = (KB > 1) ? $clog2(KB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            acc_en,
    input  logic [IA_W-1:0] idx_a,
    input  logic [IB_W-1:0] idx_b,
    input  logic [PW-1:0]   pp,
    output logic [AW-1:0]   acc
);
    logic [AW-1:0] term [NP];
    logic [AW-1:0] placed;

    for (genvar gi = 0; gi < KA; gi++) begin : g_a
        for (genvar gj = 0; gj < KB; gj++) begin : g_b
            localparam int OFF = gi * WA + gj * WB;
            assign term[gi*KB + gj] =
                ((idx_a == IA_W'(gi)) && (idx_b == IB_W'(gj)))
                    ? (AW'(pp) << OFF) : '0;
        end
    end

    always_comb begin
        placed = '0;
        for (int k = 0; k < NP; k++) begin
            placed = placed ^ term[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (acc_en) begin
            acc <= acc ^ placed;
        end
    end
endmodule

// File: rtl/seg_clmul.sv
module seg_clmul #(
    parameter int M          = 16,
    parameter int CORE_W     = 6,
    parameter bit ASYMMETRIC = 1'b0,
    parameter int ASYM_WA    = 1,
    parameter int ASYM_WB    = M
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [M-1:0]   a,
    input  logic [M-1:0]   b,
    output logic           done,
    output logic [2*M-2:0] product
);
    localparam int WA   = ASYMMETRIC ? ASYM_WA : CORE_W;
    localparam int WB   = ASYMMETRIC ? ASYM_WB : CORE_W;
    localparam int KA   = (M + WA - 1) / WA;
    localparam int KB   = (M + WB - 1) / WB;
    localparam int PW   = WA + WB - 1;
    localparam int AW   = KA * WA + KB * WB - 1;
    localparam int PRW  = 2 * M - 1;
    localparam int IA_W = (KA > 1) ? $clog2(KA) : 1;
    localparam int IB_W = (KB > 1) ? $clog2(KB) : 1;

    logic [IA_W-1:0] idx_a;
    logic [IB_W-1:0] idx_b;
    logic            load, acc_en, busy;
    logic [WA-1:0]   seg_a;
    logic [WB-1:0]   seg_b;
    logic [PW-1:0]   pp;
    logic [AW-1:0]   acc;

    seg_clmul_seq #(.KA(KA), .KB(KB)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .idx_a  (idx_a),
        .idx_b  (idx_b),
        .load   (load),
        .acc_en (acc_en),
        .busy   (busy),
        .done   (done)
    );

    seg_clmul_opreg #(.M(M), .WA(WA), .WB(WB), .KA(KA), .KB(KB)) u_opreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .a_in  (a),
        .b_in  (b),
        .idx_a (idx_a),
        .idx_b (idx_b),
        .seg_a (seg_a),
        .seg_b (seg_b)
    );

    seg_clmul_core #(.WA(WA), .WB(WB)) u_core (
        .op_a (seg_a),
        .op_b (seg_b),
        .pp   (pp)
    );

    seg_clmul_acc #(.WA(WA), .WB(WB), .KA(KA), .KB(KB)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .acc_en (acc_en),
        .idx_a  (idx_a),
        .idx_b  (idx_b),
        .pp     (pp),
        .acc    (acc)
    );

    assign product = acc[PRW-1:0];

    // Bits above 2M-2 stay zero because the operands are zero-extended.
    if (AW > PRW) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^acc[AW-1:PRW];
    end
endmodule

// File: rtl/seg_clmul_chk.sv
module seg_clmul_chk #(
    parameter int LAT = 9,
    parameter int PRW = 31
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [PRW-1:0] product
);
    logic        accept;
    logic        hold;
    logic [31:0] cnt;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= 1'b0;
            cnt  <= '0;
        end else begin
            if (accept)    hold <= 1'b0;
            else if (done) hold <= 1'b1;
            if (accept)    cnt <= '0;
            else if (busy) cnt <= cnt + 32'd1;
        end
    end

    // R2 R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == 32'(LAT)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || hold) && !accept) |=> $stable(product));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);

    // R9
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (product == '0));
endmodule

bind seg_clmul seg_clmul_chk #(.LAT(KA * KB), .PRW(PRW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/seg_clmul_bench.sv
module seg_clmul_bench;
    localparam int M    = 16;
    localparam int CW   = 6;
    localparam int KS   = (M + CW - 1) / CW;
    localparam int LATY = KS * KS;   // square instance
    localparam int LATS = M;         // bit-serial instance
    localparam int PRW  = 2 * M - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           start_y = 1'b0, start_s = 1'b0;
    logic [M-1:0]   a_y = '0, b_y = '0, a_s = '0, b_s = '0;
    logic           done_y, done_s;
    logic [PRW-1:0] prod_y, prod_s;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    seg_clmul #(.M(M), .CORE_W(CW)) u_seg_clmul (
        .clk(clk), .rst_n(rst_n), .start(start_y), .a(a_y), .b(b_y),
        .done(done_y), .product(prod_y)
    );

    seg_clmul #(.M(M), .ASYMMETRIC(1'b1), .ASYM_WA(1), .ASYM_WB(M)) u_seg_clmul_serial (
        .clk(clk), .rst_n(rst_n), .start(start_s), .a(a_s), .b(b_s),
        .done(done_s), .product(prod_s)
    );

    function automatic logic [PRW-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [PRW-1:0] r = '0;
        for (int i = 0; i < M; i++) begin
            if (x[i]) r = r ^ (PRW'(y) << i);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [PRW-1:0] act,
                         input logic [PRW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input bit ser, input bit st, input logic [M-1:0] x,
                         input logic [M-1:0] y);
        if (ser) begin start_s = st; a_s = x; b_s = y; end
        else     begin start_y = st; a_y = x; b_y = y; end
    endtask

    // One operation; poke pulses start with other operands mid-run (R5).
    task automatic do_mul(input bit ser, input logic [M-1:0] x, input logic [M-1:0] y,
                          input bit poke);
        int lat = ser ? LATS : LATY;
        string lreq = ser ? "R7" : "R2";
        logic [PRW-1:0] exp = ref_mul(x, y);
        logic [PRW-1:0] held;
        @(negedge clk);
        drive(ser, 1'b1, x, y);
        @(negedge clk);
        drive(ser, 1'b0, ~x, ~y);
        // R9: accumulator cleared by the accepted start
        check((ser ? prod_s : prod_y) == '0, "R9 clear", ser ? prod_s : prod_y, '0);
        for (int c = 1; c < lat; c++) begin
            @(negedge clk);
            check((ser ? done_s : done_y) == 1'b0, {lreq, " early done"},
                  PRW'(ser ? done_s : done_y), '0);
            if (poke && c == 2) drive(ser, 1'b1, y, x ^ 16'h5a5a);
            if (poke && c == 3) drive(ser, 1'b0, 16'h1234, 16'h4321);
        end
        @(negedge clk);
        check((ser ? done_s : done_y) == 1'b1, {lreq, " done at latency"},
              PRW'(ser ? done_s : done_y), 1);
        // R1 R6 (R5 when poked, R7 on the serial instance)
        check((ser ? prod_s : prod_y) == exp,
              poke ? "R5 ignored start result" : (ser ? "R1 R7 product" : "R1 R6 product"),
              ser ? prod_s : prod_y, exp);
        held = ser ? prod_s : prod_y;
        drive(ser, 1'b0, 16'hffff, 16'hffff);
        @(negedge clk);
        check((ser ? done_s : done_y) == 1'b0, "R3 single-cycle done",
              PRW'(ser ? done_s : done_y), 0);
        repeat (2) @(negedge clk);
        check((ser ? prod_s : prod_y) == held, "R4 product hold",
              ser ? prod_s : prod_y, held);
    endtask

    initial begin
        logic [M-1:0] ra, rb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8
        check(done_y == 1'b0 && done_s == 1'b0, "R8 reset done", PRW'({done_y, done_s}), 0);
        check(prod_y == '0 && prod_s == '0, "R8 reset product", prod_y | prod_s, '0);
        rst_n = 1'b1;

        for (int s = 0; s < 2; s++) begin
            do_mul(s[0], '1, '1, 1'b0);
            do_mul(s[0], 16'h0000, 16'hbeef, 1'b0);
            do_mul(s[0], 16'h0001, 16'h0001, 1'b0);
            do_mul(s[0], 16'h8000, 16'h8000, 1'b0);
            do_mul(s[0], 16'h8000, '1, 1'b0);
            do_mul(s[0], 16'hc3a5, 16'h7e01, 1'b1);
            for (int n = 0; n < 30; n++) begin
                ra = M'($urandom);
                rb = M'($urandom);
                do_mul(s[0], ra, rb, (n % 7) == 3);
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule